// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It supports a small integer instruction set. The register forms of add, sub, and, or and set-on-less-than are supported, along with immediate add, and and or. It also supports word load, word store and branch-if-equal. The program counter, the register file, and the write strobes to data memory change state only at the rising edge that ends each instruction. No register holds a partial result between stages.

Instruction memory is read combinationally: the core presents the program counter on its fetch address and uses the returned word directly as the current instruction. Data memory is also read combinationally, and it is written at the clock edge while the store strobe is high. The core computes the sequential address with its own adder and the branch target with a second adder, so the ALU is free to do the operand work.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0, and `dmem_wr`/`dmem_rd` stay low whatever instruction is fetched.
- R2: Each non-branch instruction advances `imem_addr` by exactly 4 at the next edge, and `imem_addr[1:0]` is always 0.
- R3: Opcode 0x00 with funct 0x20/0x22/0x24/0x25/0x2A performs add, sub, and, or and signed less-than (result 1 or 0) on rs (bits 25:21) and rt (bits 20:16), and writes the result to rd (bits 15:11).
- R4: Opcodes 0x08/0x0C/0x0D perform add/and/or of rs with the sign-extended bits 15:0, and write the result to rt.
- R5: Load (opcode 0x23) drives `dmem_addr` = rs + sign-extended offset, raises `dmem_rd`, and writes `dmem_rdata` to rt.
- R6: Store (opcode 0x2B) drives `dmem_addr` = rs + sign-extended offset and `dmem_wdata` = rt, raises `dmem_wr`, and writes no register.
- R7: Branch (opcode 0x04) goes to PC+4+(sign-extended offset << 2) when rs equals rt, and to PC+4 otherwise. Both forward and backward offsets are supported.
- R8: Register 0 reads as zero; writes to it are discarded.
- R9: An unknown opcode, or an unknown funct under opcode 0x00, changes no register and no memory, and only advances the PC by 4.
- R10: An instruction that reads and writes the same register uses the value held before its own edge.
- R11: `dmem_rd` is high only for loads, and `dmem_wr` only for stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch byte address (program counter) |
| imem_word | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Data byte address from the ALU |
| dmem_wdata | output | 32 | Store data (rt value) |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational |
| dmem_rd | output | 1 | Load strobe |
| dmem_wr | output | 1 | Store strobe, written at the rising edge |

## Verification
The assertions assume that `imem_word` and `dmem_rdata` are settled, known values in every cycle after reset. They also assume that a fetched word belongs to the address the core presented in that cycle. The stimulus meets these conditions in several ways. The bench's memories answer combinationally from the presented address, and every register is written before random code reads it. Random loads and stores use register 0 as the base, so their addresses stay within the modelled 64-word data window. Random branches jump only forward, so every run reaches the end of the program; only the directed part contains a backward branch, and that branch is guarded.

// File: rtl/core_pkg.sv
package core_pkg;

    parameter int XLEN = 32;
    parameter int RIDX = 5;
    localparam int NREG = 1 << RIDX;
    localparam int IMMW = 16;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RIDX-1:0] ridx_t;

    // opcode values (bits 31:26)
    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_ANDI = 6'h0C;
    localparam logic [5:0] OPC_ORI  = 6'h0D;
    localparam logic [5:0] OPC_LW   = 6'h23;
    localparam logic [5:0] OPC_SW   = 6'h2B;

    // function values (bits 5:0) under OPC_REG
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic    reg_wr;
        logic    dst_rt;
        logic    src_imm;
        logic    wb_mem;
        logic    mem_rd;
        logic    mem_wr;
        logic    branch;
        alu_op_e alu_op;
    } ctrl_t;

    typedef struct packed {
        logic [5:0]      opc;
        ridx_t           rs;
        ridx_t           rt;
        ridx_t           rd;
        logic [4:0]      shamt;
        logic [5:0]      fn;
    } insn_t;

    function automatic word_t sext_imm(input logic [IMMW-1:0] v);
        return {{(XLEN-IMMW){v[IMMW-1]}}, v};
    endfunction

    function automatic ctrl_t ctrl_idle();
        ctrl_t c;
        c = '0;
        c.alu_op = ALU_ADD;
        return c;
    endfunction

endpackage

// File: rtl/ctrl_decode.sv
module ctrl_decode
    import core_pkg::*;
(
    input  logic [5:0] opc,
    input  logic [5:0] fn,
    output ctrl_t      ctl
);

    always_comb begin
        ctl = ctrl_idle();
        unique case (opc)
            OPC_REG: begin
                // R3 / R9: known functions write rd, others are no-ops
                ctl.reg_wr = 1'b1;
                unique case (fn)
                    FN_ADD:  ctl.alu_op = ALU_ADD;
                    FN_SUB:  ctl.alu_op = ALU_SUB;
                    FN_AND:  ctl.alu_op = ALU_AND;
                    FN_OR:   ctl.alu_op = ALU_OR;
                    FN_SLT:  ctl.alu_op = ALU_SLT;
                    default: ctl.reg_wr = 1'b0;
                endcase
            end
            OPC_ADDI, OPC_ANDI, OPC_ORI: begin
                // R4
                ctl.reg_wr  = 1'b1;
                ctl.dst_rt  = 1'b1;
                ctl.src_imm = 1'b1;
                ctl.alu_op  = (opc == OPC_ADDI) ? ALU_ADD :
                              (opc == OPC_ANDI) ? ALU_AND : ALU_OR;
            end
            OPC_LW: begin
                // R5
                ctl.reg_wr  = 1'b1;
                ctl.dst_rt  = 1'b1;
                ctl.src_imm = 1'b1;
                ctl.wb_mem  = 1'b1;
                ctl.mem_rd  = 1'b1;
            end
            OPC_SW: begin
                // R6
                ctl.src_imm = 1'b1;
                ctl.mem_wr  = 1'b1;
            end
            OPC_BEQ: begin
                // R7
                ctl.branch = 1'b1;
                ctl.alu_op = ALU_SUB;
            end
            default: ctl = ctrl_idle();
        endcase
    end

endmodule

// File: rtl/reg_bank.sv
module reg_bank
    import core_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int AW = RIDX
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);

    localparam int N = 1 << AW;

    logic [W-1:0] q [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        if (g == 0) begin : g_zero
            // R8: index 0 is a constant
            assign q[g] = '0;
        end else begin : g_cell
            logic [W-1:0] r;
            always_ff @(posedge clk) begin
                if (we && wa == AW'(g)) begin
                    r <= wd;
                end
            end
            assign q[g] = r;
        end
    end

    // R10: reads see the contents held before this edge
    assign rd1 = q[ra1];
    assign rd2 = q[ra2];

endmodule

// File: rtl/alu_unit.sv
module alu_unit
    import core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);

    logic [W-1:0] diff;

    assign diff = a - b;

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = diff;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (diff == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import core_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_word,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    input  logic [31:0] dmem_rdata,
    output logic        dmem_rd,
    output logic        dmem_wr
);

    localparam word_t PC_STEP = word_t'(4);

    word_t pc_q;
    word_t pc_seq;
    word_t pc_br;
    word_t pc_nx;
    insn_t ins;
    ctrl_t ctl;
    word_t imm_x;
    word_t rs_v;
    word_t rt_v;
    word_t opb;
    word_t alu_y;
    logic  alu_z;
    word_t wb_v;
    ridx_t dst;
    logic  rf_we;

    // no instruction register: the fetched word is decoded directly
    assign imem_addr = pc_q;
    assign ins       = insn_t'(imem_word);
    assign imm_x     = sext_imm(imem_word[IMMW-1:0]);

    ctrl_decode u_dec (
        .opc (ins.opc),
        .fn  (ins.fn),
        .ctl (ctl)
    );

    assign dst   = ctl.dst_rt ? ins.rt : ins.rd;
    assign rf_we = ctl.reg_wr & ~rst;  // R1

    reg_bank #(.W(XLEN), .AW(RIDX)) u_rf (
        .clk (clk),
        .we  (rf_we),
        .wa  (dst),
        .wd  (wb_v),
        .ra1 (ins.rs),
        .ra2 (ins.rt),
        .rd1 (rs_v),
        .rd2 (rt_v)
    );

    assign opb = ctl.src_imm ? imm_x : rt_v;

    alu_unit #(.W(XLEN)) u_alu (
        .op   (ctl.alu_op),
        .a    (rs_v),
        .b    (opb),
        .y    (alu_y),
        .zero (alu_z)
    );

    assign wb_v = ctl.wb_mem ? dmem_rdata : alu_y;

    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_v;
    assign dmem_rd    = ctl.mem_rd & ~rst;
    assign dmem_wr    = ctl.mem_wr & ~rst;

    // R2 / R7: separate adders for the sequential and branch paths
    assign pc_seq = pc_q + PC_STEP;
    assign pc_br  = pc_seq + (imm_x << 2);
    assign pc_nx  = (ctl.branch && alu_z) ? pc_br : pc_seq;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_nx;
        end
    end

endmodule

// File: rtl/core_chk.sv
module core_chk
    import core_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_word,
    input logic        dmem_rd,
    input logic        dmem_wr
);

    logic [31:0] br_off;
    assign br_off = {{14{imem_word[15]}}, imem_word[15:0], 2'b00};

    p_reset_pc_r1: assert property (@(posedge clk)
        rst |=> (imem_addr == 32'd0));

    p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
        (imem_word[31:26] != OPC_BEQ) |=> (imem_addr == $past(imem_addr) + 32'd4));

    p_align_r2: assert property (@(posedge clk) disable iff (rst)
        imem_addr[1:0] == 2'b00);

    p_branch_r7: assert property (@(posedge clk) disable iff (rst)
        (imem_word[31:26] == OPC_BEQ) |=>
            ((imem_addr == $past(imem_addr) + 32'd4) ||
             (imem_addr == $past(imem_addr) + 32'd4 + $past(br_off))));

    p_load_rd_r5: assert property (@(posedge clk) disable iff (rst)
        (imem_word[31:26] == OPC_LW) |-> (dmem_rd && !dmem_wr));

    p_wr_only_sw_r11: assert property (@(posedge clk) disable iff (rst)
        dmem_wr |-> (imem_word[31:26] == OPC_SW));

    p_rd_only_lw_r11: assert property (@(posedge clk) disable iff (rst)
        dmem_rd |-> (imem_word[31:26] == OPC_LW));

endmodule

bind sc_core core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .imem_word (imem_word),
    .dmem_rd   (dmem_rd),
    .dmem_wr   (dmem_wr)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;

    localparam int CLK_PERIOD = 10;
    localparam int PSIZE      = 1024;
    localparam int DWORDS     = 64;
    localparam int NRAND      = 300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_word;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_rd, dmem_wr;

    logic [31:0] prog [PSIZE];
    logic [31:0] dm   [DWORDS];

    logic [31:0] mreg [32];
    logic [31:0] mdm  [DWORDS];
    logic [31:0] mpc;

    bit          probe_on  [64];
    logic [31:0] probe_val [64];
    string       probe_tag [64];

    int    n_chk = 0;
    int    n_bad = 0;
    int    end_idx;
    string pc_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_core u0 (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_word  (imem_word),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .dmem_rd    (dmem_rd),
        .dmem_wr    (dmem_wr)
    );

    assign imem_word  = prog[imem_addr[11:2]];
    assign dmem_rdata = dm[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_wr) dm[dmem_addr[7:2]] <= dmem_wdata;
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic probe(input int idx, input logic [31:0] v, input string tag);
        probe_on[idx]  = 1'b1;
        probe_val[idx] = v;
        probe_tag[idx] = tag;
    endtask

    // reference model: check this cycle's outputs, then retire the instruction
    task automatic step();
        logic [31:0] w, a, b, imm, wv, ea, npc;
        logic [5:0]  op, fn;
        int          rs, rt, rd, wdst, idx;
        bit          wen, erd, ewr;
        w   = prog[mpc[11:2]];
        idx = int'(mpc[11:2]);
        op  = w[31:26];
        fn  = w[5:0];
        rs  = int'(w[25:21]);
        rt  = int'(w[20:16]);
        rd  = int'(w[15:11]);
        imm = {{16{w[15]}}, w[15:0]};
        a   = (rs == 0) ? 32'd0 : mreg[rs];
        b   = (rt == 0) ? 32'd0 : mreg[rt];
        wen = 1'b0; erd = 1'b0; ewr = 1'b0;
        wv  = '0; wdst = 0; ea = '0;
        npc = mpc + 32'd4;
        check(imem_addr == mpc, pc_tag, imem_addr, mpc);
        case (op)
            6'h00: begin
                wdst = rd; wen = 1'b1;
                case (fn)
                    6'h20: wv = a + b;
                    6'h22: wv = a - b;
                    6'h24: wv = a & b;
                    6'h25: wv = a | b;
                    6'h2A: wv = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: wen = 1'b0;
                endcase
            end
            6'h08: begin wdst = rt; wen = 1'b1; wv = a + imm; end
            6'h0C: begin wdst = rt; wen = 1'b1; wv = a & imm; end
            6'h0D: begin wdst = rt; wen = 1'b1; wv = a | imm; end
            6'h23: begin
                ea = a + imm; erd = 1'b1;
                wdst = rt; wen = 1'b1; wv = mdm[ea[7:2]];
                check(dmem_addr == ea, "R5 load address", dmem_addr, ea);
            end
            6'h2B: begin
                ea = a + imm; ewr = 1'b1;
                check(dmem_addr == ea, "R6 store address", dmem_addr, ea);
                check(dmem_wdata == b, "R6 store data", dmem_wdata, b);
                mdm[ea[7:2]] = b;
            end
            6'h04: begin
                if (a == b) npc = mpc + 32'd4 + (imm << 2);
            end
            default: ;
        endcase
        check({dmem_rd, dmem_wr} == {erd, ewr}, "R11 strobes",
              {30'd0, dmem_rd, dmem_wr}, {30'd0, erd, ewr});
        if (idx < 64 && probe_on[idx]) begin
            check(dmem_wdata == probe_val[idx], probe_tag[idx], dmem_wdata, probe_val[idx]);
        end
        if (wen && wdst != 0) mreg[wdst] = wv;
        pc_tag = (op == 6'h04) ? "R7 next pc" : "R2 next pc";
        mpc = npc;
    endtask

    task automatic build();
        int          p;
        logic [5:0]  fns [6];
        fns = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h3F};
        for (int i = 0; i < PSIZE; i++) prog[i] = 32'd0;
        for (int i = 0; i < 64; i++) probe_on[i] = 1'b0;
        prog[0]  = enc_i(6'h08, 0, 1, 16'd7);
        prog[1]  = enc_i(6'h08, 0, 2, 16'hFFFD);
        prog[2]  = enc_r(1, 2, 3, 6'h20);
        prog[3]  = enc_r(2, 1, 4, 6'h22);
        prog[4]  = enc_r(4, 1, 5, 6'h2A);
        prog[5]  = enc_r(1, 4, 6, 6'h2A);
        prog[6]  = enc_r(1, 2, 7, 6'h24);
        prog[7]  = enc_r(1, 2, 8, 6'h25);
        prog[8]  = enc_i(6'h0D, 0, 9, 16'h8000);
        prog[9]  = enc_i(6'h08, 0, 0, 16'd5);
        prog[10] = enc_i(6'h2B, 0, 3, 16'd0);  probe(10, 32'd4, "R3 add");
        prog[11] = enc_i(6'h2B, 0, 4, 16'd4);  probe(11, 32'hFFFFFFF6, "R3 sub");
        prog[12] = enc_i(6'h2B, 0, 5, 16'd8);  probe(12, 32'd1, "R3 slt true");
        prog[13] = enc_i(6'h2B, 0, 6, 16'd12); probe(13, 32'd0, "R3 slt false");
        prog[14] = enc_i(6'h2B, 0, 7, 16'd16); probe(14, 32'd5, "R3 and");
        prog[15] = enc_i(6'h2B, 0, 8, 16'd20); probe(15, 32'hFFFFFFFF, "R3 or");
        prog[16] = enc_i(6'h2B, 0, 9, 16'd24); probe(16, 32'hFFFF8000, "R4 ori sign extend");
        prog[17] = enc_i(6'h2B, 0, 0, 16'd28); probe(17, 32'd0, "R8 r0 stays zero");
        prog[18] = enc_i(6'h08, 1, 1, 16'd1);
        prog[19] = enc_i(6'h2B, 0, 1, 16'd32); probe(19, 32'd8, "R10 read old value");
        prog[20] = enc_i(6'h23, 0, 10, 16'd32);
        prog[21] = enc_i(6'h2B, 0, 10, 16'd36); probe(21, 32'd8, "R5 load data");
        prog[22] = enc_i(6'h08, 0, 11, 16'd5);
        prog[23] = enc_i(6'h04, 1, 10, 16'd1);
        prog[24] = enc_i(6'h08, 0, 11, 16'd99);
        prog[25] = enc_i(6'h04, 1, 2, 16'd1);
        prog[26] = enc_i(6'h3F, 0, 11, 16'd77);
        prog[27] = enc_r(1, 1, 11, 6'h3F);
        prog[28] = enc_i(6'h2B, 0, 11, 16'd40); probe(28, 32'd5, "R9 unknown codes no write");
        prog[29] = enc_i(6'h04, 0, 0, 16'd3);
        prog[30] = enc_i(6'h08, 0, 12, 16'd1);
        prog[31] = enc_i(6'h04, 0, 0, 16'd2);
        prog[33] = enc_i(6'h04, 0, 0, 16'hFFFC);
        prog[34] = enc_i(6'h2B, 0, 12, 16'd44); probe(34, 32'd1, "R7 backward branch");
        p = 35;
        for (int r = 1; r < 32; r++) begin
            prog[p] = enc_i(6'h08, 0, r, 16'($urandom)); p++;
        end
        for (int k = 0; k < NRAND; k++) begin
            int kind;
            kind = int'($urandom_range(0, 9));
            case (kind)
                0, 1, 2: prog[p] = enc_r(int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                                         int'($urandom_range(0, 31)), fns[$urandom_range(0, 5)]);
                3: prog[p] = enc_i(6'h08, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), 16'($urandom));
                4: prog[p] = enc_i(6'h0C, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), 16'($urandom));
                5: prog[p] = enc_i(6'h0D, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), 16'($urandom));
                6: prog[p] = enc_i(6'h23, 0, int'($urandom_range(0, 31)), 16'($urandom_range(0, 63) * 4));
                7: prog[p] = enc_i(6'h2B, 0, int'($urandom_range(0, 31)), 16'($urandom_range(0, 63) * 4));
                8: prog[p] = enc_i(6'h04, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                                   16'($urandom_range(0, 3)));
                default: prog[p] = enc_i(6'h3E, 1, int'($urandom_range(1, 31)), 16'($urandom));
            endcase
            p++;
        end
        for (int r = 0; r < 32; r++) begin
            prog[p] = enc_i(6'h2B, 0, r, 16'(r * 4)); p++;
        end
        end_idx = p;
    endtask

    initial begin : main
        int cyc;
        void'($urandom(32'd20240611));
        build();
        for (int i = 0; i < DWORDS; i++) begin
            dm[i]  = $urandom;
            mdm[i] = dm[i];
        end
        for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
        // R1: a store fetched during reset must not strobe
        prog[0] = enc_i(6'h2B, 0, 0, 16'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(imem_addr == 32'd0, "R1 reset pc", imem_addr, 32'd0);
        check(dmem_wr == 1'b0, "R1 no store in reset", {31'd0, dmem_wr}, 32'd0);
        prog[0] = enc_i(6'h08, 0, 1, 16'd7);
        rst     = 1'b0;
        mpc     = 32'd0;
        pc_tag  = "R1 first pc";
        #1;
        step();
        cyc = 0;
        while (int'(mpc[31:2]) < end_idx && cyc < 5000) begin
            @(negedge clk);
            #1;
            step();
            cyc++;
        end
        if (cyc >= 5000) check(1'b0, "watchdog", 32'(cyc), 32'(end_idx));
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule